// File: doc/BRIEF.md
# VMEbus System Controller Timers

This block carries the system-controller duties of a VMEbus board. When reset is released it samples the active-low level-3 bus-grant input once. A low level means no board sits to the left, so the board is in the first slot and takes the system-controller role. Software may later set or clear that role through a control register. The same register selects the data-transfer time-out, the arbitration mode and the arbitration time-out.

Two watchdog counters run from a one-cycle microsecond tick input. The transfer watchdog counts while a data strobe is asserted and raises a one-cycle bus error when its limit is reached. The arbitration watchdog counts on an 8 µs grain derived from the same tick. It runs while a request is pending and the bus is not busy, and it raises a one-cycle time-out so the arbiter can withdraw its grant. Two write-only control bits give one-cycle reset requests, one toward VMEbus and one toward the local bus.

Top module: `vme_sysctl_timers`

## Requirements
- R1: Reset clears the system-controller enable. In the first clock cycle after reset is released, the enable is loaded with the inverse of `grant_in_n`: a low level enables the role and a high level disables it.
- R2: Writing the control register loads the enable from bit 17. A write in the sampling cycle takes priority over the sampled value.
- R3: The control register answers only at byte address 0x404. It reads back the transfer code in [31:28], the mode in bit 26, the arbitration code in [25:24] and the enable in bit 17, with every other bit reading 0. After reset it reads 0x3100_0000 plus the enable bit. Writes to other addresses change nothing, and reads at other addresses return 0.
- R4: With the data strobe held and a transfer code c in 1..7, `bus_err` is high for exactly one cycle, in the cycle after the clock edge that samples the (16·2^(c−1))-th tick. It stays low for the rest of that strobe.
- R5: Negating the data strobe for one cycle clears the transfer count, so a new strobe needs the full limit again.
- R6: `bus_err` and `arb_timeout` stay low while the system-controller enable is 0.
- R7: Transfer codes 0 and 8 to 15 disable the transfer watchdog.
- R8: Bit 26 drives `arb_prio` (0 for round-robin, 1 for fixed priority) and resets to 0.
- R9: Every 8th microsecond tick counted from reset is an 8 µs grain. While `bus_req` is high and `bus_busy` is low, arbitration code 01 pulses `arb_timeout` for one cycle at the 2nd grain boundary, and code 10 at the 32nd. Setting `bus_busy` holds the count at zero.
- R10: Arbitration codes 00 and 11 disable the arbitration watchdog.
- R11: Writing 1 to bit 22 gives a one-cycle `vme_rst_req` in the cycle after the write. Writing 0 gives no pulse. The bit reads 0.
- R12: Writing 1 to bit 23 gives a one-cycle `local_rst_req` in the cycle after the write. Writing 0 gives no pulse. The bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grant_in_n | input | 1 | Level-3 bus-grant daisy-chain input, active low |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| ds_active | input | 1 | Data strobe asserted on the bus |
| bus_req | input | 1 | Bus request pending at the arbiter |
| bus_busy | input | 1 | Bus busy asserted |
| sysctl_en | output | 1 | System-controller role enabled |
| arb_prio | output | 1 | Arbitration mode: 0 round-robin, 1 fixed priority |
| bus_err | output | 1 | Transfer time-out bus error pulse |
| arb_timeout | output | 1 | Arbitration time-out pulse |
| vme_rst_req | output | 1 | VMEbus system reset request pulse |
| local_rst_req | output | 1 | Local-bus reset request pulse |

## Verification
The bench goes after the exact expiry tick for the shortest, the default and the longest transfer codes. A counter off by one would fire a tick early or late, and a watchdog that re-arms inside a strobe would give a second pulse. The arbitration expiry is predicted from the tick count since reset, so a prescaler that restarts when a request arrives would fire a whole grain late. Reserved codes, a busy bus, a disabled controller role and writes to neighbouring addresses are each checked for silence, because a design that decodes loosely would fire or change state there. A write that lands in the sampling cycle must win, or the software setting is lost at power-up.

// File: rtl/vme_sysctl_pkg.sv
package vme_sysctl_pkg;

    localparam int REG_W       = 32;
    localparam int BTO_LSB     = 28;
    localparam int PRIO_BIT    = 26;
    localparam int ARBTO_LSB   = 24;
    localparam int LRST_BIT    = 23;
    localparam int VRST_BIT    = 22;
    localparam int SYSCTL_BIT  = 17;

    localparam logic [3:0] BTO_RESET   = 4'b0011;
    localparam logic [1:0] ARBTO_RESET = 2'b01;

    typedef struct packed {
        logic [3:0] bto;
        logic       prio;
        logic [1:0] arbto;
        logic       sysctl;
    } ctl_t;

    // Transfer limit in microsecond ticks; 0 means disabled.
    function automatic int bto_limit_us(input logic [3:0] code);
        if (code >= 4'd1 && code <= 4'd7)
            return 16 << (int'(code) - 1);
        return 0;
    endfunction

    // Arbitration limit in 8 us grains; 0 means disabled.
    function automatic int arb_limit_grains(input logic [1:0] code);
        case (code)
            2'b01:   return 2;
            2'b10:   return 32;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/vme_to_timer.sv
module vme_to_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             active,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fired;
        logic             pulse;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (!active) begin
            st_d.cnt   = '0;
            st_d.fired = 1'b0;
        end else if (tick && !st_q.fired && limit != '0) begin
            if (({1'b0, st_q.cnt} + 1'b1) >= {1'b0, limit}) begin
                st_d.cnt   = '0;
                st_d.fired = 1'b1;
                st_d.pulse = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expire = st_q.pulse;

endmodule

// File: rtl/vme_sysctl_regs.sv
module vme_sysctl_regs
    import vme_sysctl_pkg::*;
#(
    parameter int              ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h404
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_in_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output ctl_t              ctl,
    output logic              vme_rst_req,
    output logic              local_rst_req
);

    typedef struct packed {
        ctl_t ctl;
        logic sampled;
        logic vme_req;
        logic loc_req;
    } st_t;

    st_t  st_d, st_q;
    logic sel;

    assign sel = (reg_addr == REG_OFFSET);

    always_comb begin
        st_d         = st_q;
        st_d.vme_req = 1'b0;
        st_d.loc_req = 1'b0;
        if (!st_q.sampled) begin
            st_d.sampled    = 1'b1;
            st_d.ctl.sysctl = ~grant_in_n;
        end
        if (reg_wr && sel) begin
            st_d.ctl.bto    = reg_wdata[BTO_LSB +: 4];
            st_d.ctl.prio   = reg_wdata[PRIO_BIT];
            st_d.ctl.arbto  = reg_wdata[ARBTO_LSB +: 2];
            st_d.ctl.sysctl = reg_wdata[SYSCTL_BIT];
            st_d.vme_req    = reg_wdata[VRST_BIT];
            st_d.loc_req    = reg_wdata[LRST_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctl.bto    <= BTO_RESET;
            st_q.ctl.prio   <= 1'b0;
            st_q.ctl.arbto  <= ARBTO_RESET;
            st_q.ctl.sysctl <= 1'b0;
            st_q.sampled    <= 1'b0;
            st_q.vme_req    <= 1'b0;
            st_q.loc_req    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sel) begin
            reg_rdata[BTO_LSB +: 4]   = st_q.ctl.bto;
            reg_rdata[PRIO_BIT]       = st_q.ctl.prio;
            reg_rdata[ARBTO_LSB +: 2] = st_q.ctl.arbto;
            reg_rdata[SYSCTL_BIT]     = st_q.ctl.sysctl;
        end
    end

    assign ctl           = st_q.ctl;
    assign vme_rst_req   = st_q.vme_req;
    assign local_rst_req = st_q.loc_req;

endmodule

// File: rtl/vme_sysctl_timers.sv
module vme_sysctl_timers
    import vme_sysctl_pkg::*;
#(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h404,
    parameter int                BTO_CNT_W  = 11,
    parameter int                ARB_CNT_W  = 6,
    parameter int                PRESCALE   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_in_n,
    input  logic              us_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ds_active,
    input  logic              bus_req,
    input  logic              bus_busy,
    output logic              sysctl_en,
    output logic              arb_prio,
    output logic              bus_err,
    output logic              arb_timeout,
    output logic              vme_rst_req,
    output logic              local_rst_req
);

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } st_t;

    st_t  st_d, st_q;
    ctl_t ctl;
    logic grain_tick;
    logic bto_fire, arb_fire;
    logic [3:0] bto_code;
    logic [1:0] arbto_code;
    logic [BTO_CNT_W-1:0] bto_limit;
    logic [ARB_CNT_W-1:0] arb_limit;

    vme_sysctl_regs #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .grant_in_n    (grant_in_n),
        .reg_wr        (reg_wr),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .ctl           (ctl),
        .vme_rst_req   (vme_rst_req),
        .local_rst_req (local_rst_req)
    );

    // Free-running microsecond prescaler giving the arbitration grain.
    always_comb begin
        st_d       = st_q;
        grain_tick = us_tick && (st_q.pre == PRE_LAST);
        if (us_tick)
            st_d.pre = grain_tick ? '0 : st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bto_code   = ctl.bto;
    assign arbto_code = ctl.arbto;
    assign bto_limit  = BTO_CNT_W'(bto_limit_us(bto_code));
    assign arb_limit  = ARB_CNT_W'(arb_limit_grains(arbto_code));

    vme_to_timer #(.CNT_W(BTO_CNT_W)) u_bto (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (us_tick),
        .active (ds_active),
        .limit  (bto_limit),
        .expire (bto_fire)
    );

    vme_to_timer #(.CNT_W(ARB_CNT_W)) u_arbto (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (grain_tick),
        .active (bus_req && !bus_busy),
        .limit  (arb_limit),
        .expire (arb_fire)
    );

    assign sysctl_en   = ctl.sysctl;
    assign arb_prio    = ctl.prio;
    assign bus_err     = bto_fire && ctl.sysctl;
    assign arb_timeout = arb_fire && ctl.sysctl;

endmodule

// File: rtl/vme_sysctl_timers_chk.sv
module vme_sysctl_timers_chk #(
    parameter int                ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] REG_OFFSET = 12'h404
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              ds_active,
    input logic              bus_req,
    input logic              bus_busy,
    input logic              bus_err,
    input logic              arb_timeout,
    input logic              vme_rst_req,
    input logic              local_rst_req,
    input logic [3:0]        bto_code,
    input logic [1:0]        arbto_code
);

    p_vme_pulse_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vme_rst_req |-> $past(reg_wr && reg_addr == REG_OFFSET && reg_wdata[22]));

    p_loc_pulse_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
        local_rst_req |-> $past(reg_wr && reg_addr == REG_OFFSET && reg_wdata[23]));

    p_wo_bits_read_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[23:22] == 2'b00);

    p_berr_needs_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(ds_active));

    p_berr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |=> !bus_err);

    p_berr_valid_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> ($past(bto_code) != 4'd0 && $past(bto_code) < 4'd8));

    p_arb_needs_request_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arb_timeout |-> $past(bus_req && !bus_busy));

    p_arb_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arb_timeout |=> !arb_timeout);

    p_arb_valid_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arb_timeout |-> ($past(arbto_code) == 2'b01 || $past(arbto_code) == 2'b10));

endmodule

bind vme_sysctl_timers vme_sysctl_timers_chk #(
    .ADDR_W     (ADDR_W),
    .REG_OFFSET (REG_OFFSET)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_rdata     (reg_rdata),
    .ds_active     (ds_active),
    .bus_req       (bus_req),
    .bus_busy      (bus_busy),
    .bus_err       (bus_err),
    .arb_timeout   (arb_timeout),
    .vme_rst_req   (vme_rst_req),
    .local_rst_req (local_rst_req),
    .bto_code      (bto_code),
    .arbto_code    (arbto_code)
);

// File: tb/vme_sysctl_timers_bench.sv
module vme_sysctl_timers_bench;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam logic [11:0] OFF = 12'h404;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        grant_in_n = 1'b1;
    logic        us_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = OFF;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ds_active = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_busy = 1'b0;
    logic        sysctl_en, arb_prio, bus_err, arb_timeout, vme_rst_req, local_rst_req;

    int n_checks = 0;
    int n_fail   = 0;
    int tick_total = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vme_sysctl_timers u_vme_sysctl_timers (
        .clk(clk), .rst_n(rst_n), .grant_in_n(grant_in_n), .us_tick(us_tick),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ds_active(ds_active), .bus_req(bus_req), .bus_busy(bus_busy),
        .sysctl_en(sysctl_en), .arb_prio(arb_prio), .bus_err(bus_err),
        .arb_timeout(arb_timeout), .vme_rst_req(vme_rst_req), .local_rst_req(local_rst_req)
    );

    typedef struct packed {
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] rexp;
        logic        vme;
        logic        loc;
        logic        prio;
    } vec_t;

    // Register vectors, applied with the controller role enabled (R3, R8, R11, R12).
    localparam vec_t VECS [0:7] = '{
        '{12'h404, 32'h1502_0000, 32'h1502_0000, 1'b0, 1'b0, 1'b1},
        '{12'h404, 32'h3142_0000, 32'h3102_0000, 1'b1, 1'b0, 1'b0},
        '{12'h404, 32'h3182_0000, 32'h3102_0000, 1'b0, 1'b1, 1'b0},
        '{12'h404, 32'h71C2_0000, 32'h7102_0000, 1'b1, 1'b1, 1'b0},
        '{12'h400, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 1'b0, 1'b0},
        '{12'h404, 32'hFFFF_FFFF, 32'hF702_0000, 1'b1, 1'b1, 1'b1},
        '{12'h404, 32'h0002_0000, 32'h0002_0000, 1'b0, 1'b0, 1'b0},
        '{12'h408, 32'h1234_5678, 32'h0000_0000, 1'b0, 1'b0, 1'b0}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mkreg(input logic [3:0] bto, input logic prio,
                                          input logic [1:0] arbto, input logic sys);
        return {bto, 1'b0, prio, arbto, 2'b00, 4'b0000, sys, 17'b0};
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        step();
        reg_wr = 1'b0; reg_addr = OFF;
    endtask

    task automatic tick();
        us_tick = 1'b1;
        step();
        us_tick = 1'b0;
        tick_total++;
    endtask

    task automatic do_reset(input logic grant);
        rst_n = 1'b0; grant_in_n = grant; reg_wr = 1'b0; us_tick = 1'b0;
        ds_active = 1'b0; bus_req = 1'b0; bus_busy = 1'b0; reg_addr = OFF;
        repeat (3) step();
        rst_n = 1'b1;
        tick_total = 0;
        chk("R1 enable clear before sample", {31'b0, sysctl_en}, 32'd0);
        step();
        chk("R1 sampled enable", {31'b0, sysctl_en}, {31'b0, ~grant});
        grant_in_n = 1'b1;
    endtask

    // Hold the strobe for n ticks; exp_at = tick number of the error pulse, 0 for none.
    task automatic bus_run(input string req, input int n, input int exp_at);
        ds_active = 1'b1;
        step();
        for (int i = 1; i <= n; i++) begin
            tick();
            chk(req, {31'b0, bus_err}, {31'b0, (i == exp_at)});
        end
        ds_active = 1'b0;
        step();
    endtask

    // Keep a request pending; grains = number of grain boundaries to expiry, 0 for none.
    task automatic arb_run(input string req, input int grains, input int n);
        int target;
        bus_req = 1'b1;
        step();
        target = (tick_total / 8 + 1) * 8 + (grains - 1) * 8;
        for (int i = 0; i < n; i++) begin
            tick();
            chk(req, {31'b0, arb_timeout},
                {31'b0, (grains != 0 && tick_total == target)});
        end
        bus_req = 1'b0;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R1, R3, R8: reset with the grant low and high
        do_reset(1'b0);
        chk("R3 reset readback", reg_rdata, 32'h3102_0000);
        chk("R8 reset mode", {31'b0, arb_prio}, 32'd0);
        chk("R11 no reset pulse after reset", {31'b0, vme_rst_req}, 32'd0);
        do_reset(1'b1);
        chk("R3 reset readback role off", reg_rdata, 32'h3100_0000);

        // R2: write in the sampling cycle wins over a high grant
        rst_n = 1'b0; grant_in_n = 1'b1;
        repeat (2) step();
        rst_n = 1'b1; tick_total = 0;
        wr(OFF, mkreg(4'd3, 1'b0, 2'b01, 1'b1));
        chk("R2 write beats sample", {31'b0, sysctl_en}, 32'd1);
        wr(OFF, mkreg(4'd3, 1'b0, 2'b01, 1'b0));
        chk("R2 software clear", {31'b0, sysctl_en}, 32'd0);
        wr(OFF, mkreg(4'd3, 1'b0, 2'b01, 1'b1));
        chk("R2 software set", {31'b0, sysctl_en}, 32'd1);

        // Register vector walk
        foreach (VECS[k]) begin
            reg_addr = VECS[k].addr; reg_wdata = VECS[k].wdata; reg_wr = 1'b1;
            step();
            reg_wr = 1'b0;
            chk("R11 vme pulse", {31'b0, vme_rst_req}, {31'b0, VECS[k].vme});
            chk("R12 local pulse", {31'b0, local_rst_req}, {31'b0, VECS[k].loc});
            chk("R3 readback", reg_rdata, VECS[k].rexp);
            chk("R8 mode output", {31'b0, arb_prio}, {31'b0, VECS[k].prio});
            step();
            chk("R11 pulse one cycle", {31'b0, vme_rst_req}, 32'd0);
            chk("R12 pulse one cycle", {31'b0, local_rst_req}, 32'd0);
        end
        reg_addr = OFF;
        #1;
        chk("R3 other addresses ignored", reg_rdata, 32'h0002_0000);

        // R4: shortest, default and longest transfer limits
        wr(OFF, mkreg(4'd1, 1'b0, 2'b00, 1'b1));
        bus_run("R4 16us", 40, 16);
        wr(OFF, mkreg(4'd3, 1'b0, 2'b00, 1'b1));
        bus_run("R4 64us", 80, 64);
        wr(OFF, mkreg(4'd7, 1'b0, 2'b00, 1'b1));
        bus_run("R4 1024us", 1030, 1024);

        // R5: a gap in the strobe restarts the count
        wr(OFF, mkreg(4'd1, 1'b0, 2'b00, 1'b1));
        ds_active = 1'b1; step();
        for (int i = 0; i < 10; i++) tick();
        ds_active = 1'b0; step();
        bus_run("R5 restart after negation", 20, 16);

        // R6: role disabled masks both watchdogs
        wr(OFF, mkreg(4'd1, 1'b0, 2'b01, 1'b0));
        bus_run("R6 no bus error when role off", 40, 0);
        arb_run("R6 no arb time-out when role off", 0, 40);

        // R7: disabled and reserved transfer codes
        wr(OFF, mkreg(4'd0, 1'b0, 2'b00, 1'b1));
        bus_run("R7 code 0", 1100, 0);
        wr(OFF, mkreg(4'd8, 1'b0, 2'b00, 1'b1));
        bus_run("R7 code 8", 1100, 0);
        wr(OFF, mkreg(4'd15, 1'b0, 2'b00, 1'b1));
        bus_run("R7 code 15", 40, 0);

        // R9: arbitration expiry on the grain grid
        wr(OFF, mkreg(4'd0, 1'b0, 2'b01, 1'b1));
        arb_run("R9 16us grain", 2, 30);
        tick(); tick(); tick();
        arb_run("R9 16us offset start", 2, 30);
        wr(OFF, mkreg(4'd0, 1'b0, 2'b10, 1'b1));
        arb_run("R9 256us grain", 32, 270);
        wr(OFF, mkreg(4'd0, 1'b0, 2'b01, 1'b1));
        bus_busy = 1'b1;
        arb_run("R9 busy holds count", 0, 40);
        bus_busy = 1'b0;

        // R10: disabled and reserved arbitration codes
        wr(OFF, mkreg(4'd0, 1'b0, 2'b00, 1'b1));
        arb_run("R10 code 00", 0, 300);
        wr(OFF, mkreg(4'd0, 1'b0, 2'b11, 1'b1));
        arb_run("R10 code 11", 0, 300);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule